// File: doc/BRIEF.md
# MFM Sector Sync, Decoder and Clock-Bit Encoder

This block sits behind the read head of a floppy data path. It takes the raw track bitstream one bit at a time and hunts through the inter-sector gaps for the sector mark. The mark is the raw word 0x4489 received twice back to back. Once it has the mark, the block realigns to pair boundaries. It then takes every second raw bit as a data bit and assembles the bits into bytes, most significant bit first.

Each sector is framed as follows: a header of `HDR_LONGS` longwords, a header checksum longword, a data checksum longword, and `DATA_BYTES` payload bytes. The first header longword carries the format, track, sector and sectors-until-gap bytes. Both checksums are the bitwise XOR of the longwords they cover. The block compares each one against its stored value and raises a sticky error flag when either fails. After the last payload byte it returns to hunting, ready for the next sector on the track.

A separate write path turns data bits into clock/data pairs. It inserts a 1 clock bit only between two 0 data bits.

Top module: `mfm_track_decoder`

## Requirements
- R1: After reset, `byte_vld`, `sect_done`, `sect_err` and `enc_pair_vld` are 0.
- R2: A sector starts only when 0x4489 is received in two consecutive 16-raw-bit windows. A single 0x4489 followed by any other 16 bits produces no bytes.
- R3: After the mark, raw bits are taken in pairs (clock first, data second). Each byte is the 8 data bits, MSB first. `byte_vld` pulses for one cycle, one cycle after the 16th raw bit of the byte.
- R4: Cycles with `raw_vld` low are ignored, and so are gap bits before a mark.
- R5: Bytes 0..3 of the sector are latched on `hdr_fmt`, `hdr_trk`, `hdr_sec` and `hdr_gap`. They hold their value between byte strobes.
- R6: `hdr_good` is 1 at `sect_done` exactly when the XOR of the header longwords equals the header checksum longword (bytes 4*HDR_LONGS..+3, first byte most significant).
- R7: `dat_good` is 1 at `sect_done` exactly when the XOR of the payload longwords equals the data checksum longword (the four bytes after the header checksum).
- R8: `sect_done` pulses together with the strobe of the last payload byte. The decoder then hunts again and decodes the next sector.
- R9: `sect_err` rises one cycle after a `sect_done` with a failed checksum. It stays high until the next doubled mark.
- R10: For each `enc_vld` data bit d, `enc_pair` = {clock, d} one cycle later. The clock bit is 1 only if both d and the previous data bit are 0. The previous data bit is 0 after reset.
- R11: `byte_dat` is 1 exactly for the strobes of payload bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_vld | input | 1 | Raw bit present this cycle |
| raw_bit | input | 1 | Raw track bit |
| byte_out | output | 8 | Decoded byte |
| byte_vld | output | 1 | Decoded byte strobe |
| byte_dat | output | 1 | Strobed byte belongs to the payload |
| hdr_fmt | output | 8 | Header format byte |
| hdr_trk | output | 8 | Header track byte |
| hdr_sec | output | 8 | Header sector byte |
| hdr_gap | output | 8 | Header sectors-until-gap byte |
| sect_done | output | 1 | Sector complete pulse |
| hdr_good | output | 1 | Header checksum matches (valid at sect_done) |
| dat_good | output | 1 | Data checksum matches (valid at sect_done) |
| sect_err | output | 1 | Sticky checksum error of the last sector |
| enc_vld | input | 1 | Encoder data bit present |
| enc_bit | input | 1 | Encoder data bit |
| enc_pair | output | 2 | Encoded pair {clock, data} |
| enc_pair_vld | output | 1 | Encoded pair strobe |

## Verification
The bench builds the block with `HDR_LONGS` = 2 and `DATA_BYTES` = 16, so a sector is only 32 bytes. That makes it cheap to stream eleven sectors of a track back to back. Gaps and idle cycles are interleaved, and chosen sectors carry a corrupted header or data checksum. Every byte, header field, checksum verdict and sticky-flag transition is compared against values the bench computes itself. The small size also leaves room for a lone-mark case. The encoder is swept over every bit of all 256 byte values in sequence, which covers every previous/current data-bit combination many times.

// File: rtl/mfm_track_decoder.sv
module mfm_track_decoder #(
  parameter int HDR_LONGS  = 5,
  parameter int DATA_BYTES = 512,
  parameter logic [15:0] SYNC = 16'h4489
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_vld,
  input  logic       raw_bit,
  output logic [7:0] byte_out,
  output logic       byte_vld,
  output logic       byte_dat,
  output logic [7:0] hdr_fmt,
  output logic [7:0] hdr_trk,
  output logic [7:0] hdr_sec,
  output logic [7:0] hdr_gap,
  output logic       sect_done,
  output logic       hdr_good,
  output logic       dat_good,
  output logic       sect_err,
  input  logic       enc_vld,
  input  logic       enc_bit,
  output logic [1:0] enc_pair,
  output logic       enc_pair_vld
);
  localparam int HB    = 4 * HDR_LONGS;
  localparam int TOTAL = HB + 8 + DATA_BYTES;
  localparam int IW    = $clog2(TOTAL);

  typedef enum logic [1:0] {HUNT, SYNC2, RECV} st_t;
  st_t st;

  logic [15:0] sh;
  logic [3:0]  pos;
  logic [6:0]  part;
  logic [IW-1:0] idx;
  logic [31:0] hacc, dacc, hck, dck;
  logic        enc_prev;

  wire [15:0] sh_nx = {sh[14:0], raw_bit};
  wire [7:0]  nb    = {part, raw_bit};
  wire [31:0] lanev = {nb, 24'h0} >> {idx[1:0], 3'b000};

  assign hdr_good = (hacc == hck);
  assign dat_good = (dacc == dck);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= HUNT; sh <= '0; pos <= '0; part <= '0; idx <= '0;
      hacc <= '0; dacc <= '0; hck <= '0; dck <= '0;
      byte_out <= '0; byte_vld <= 1'b0; byte_dat <= 1'b0;
      hdr_fmt <= '0; hdr_trk <= '0; hdr_sec <= '0; hdr_gap <= '0;
      sect_done <= 1'b0; sect_err <= 1'b0;
    end else begin
      byte_vld  <= 1'b0;
      sect_done <= 1'b0;
      if (raw_vld) sh <= sh_nx;
      if (sect_done && !(hdr_good && dat_good)) sect_err <= 1'b1;
      case (st)
        HUNT: if (raw_vld && sh_nx == SYNC) begin
          st  <= SYNC2;
          pos <= '0;
        end
        SYNC2: if (raw_vld) begin
          pos <= pos + 4'd1;
          if (pos == 4'hF) begin
            if (sh_nx == SYNC) begin
              st <= RECV; idx <= '0; hacc <= '0; dacc <= '0; sect_err <= 1'b0;
            end else st <= HUNT;
          end
        end
        RECV: if (raw_vld) begin
          pos <= pos + 4'd1;
          if (pos[0]) part <= nb[6:0];
          if (pos == 4'hF) begin
            byte_out <= nb;
            byte_vld <= 1'b1;
            byte_dat <= (idx >= IW'(HB + 8));
            idx      <= idx + 1'b1;
            if (idx == IW'(0)) hdr_fmt <= nb;
            if (idx == IW'(1)) hdr_trk <= nb;
            if (idx == IW'(2)) hdr_sec <= nb;
            if (idx == IW'(3)) hdr_gap <= nb;
            if (idx < IW'(HB))            hacc <= hacc ^ lanev;
            else if (idx < IW'(HB + 4))   hck  <= {hck[23:0], nb};
            else if (idx < IW'(HB + 8))   dck  <= {dck[23:0], nb};
            else                          dacc <= dacc ^ lanev;
            if (idx == IW'(TOTAL - 1)) begin
              st        <= HUNT;
              sect_done <= 1'b1;
            end
          end
        end
        default: st <= HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc_prev <= 1'b0; enc_pair <= '0; enc_pair_vld <= 1'b0;
    end else begin
      enc_pair_vld <= enc_vld;
      if (enc_vld) begin
        enc_pair <= {~enc_prev & ~enc_bit, enc_bit};
        enc_prev <= enc_bit;
      end
    end
  end

  p_byte_needs_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(raw_vld));
  p_idle_no_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(raw_vld) |-> !byte_vld);
  p_hdr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |-> $stable(hdr_sec) && $stable(hdr_trk));
  p_done_last_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sect_done |-> byte_vld && byte_dat);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sect_err && st != SYNC2 |=> sect_err);
  p_enc_no_clock_after_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    enc_pair_vld && $past(enc_pair_vld) && $past(enc_pair[0]) |-> !enc_pair[1]);
endmodule

// File: tb/mfm_track_decoder_tb.sv
`timescale 1ns/1ps
module mfm_track_decoder_tb_top;
  localparam int HL = 2, DB = 16, HB = 4 * HL, TOT = HB + 8 + DB;

  logic clk = 0, rst_n = 0;
  logic raw_vld = 0, raw_bit = 0, enc_vld = 0, enc_bit = 0;
  logic [7:0] byte_out, hdr_fmt, hdr_trk, hdr_sec, hdr_gap;
  logic byte_vld, byte_dat, sect_done, hdr_good, dat_good, sect_err, enc_pair_vld;
  logic [1:0] enc_pair;

  always #2 clk = ~clk;

  mfm_track_decoder #(.HDR_LONGS(HL), .DATA_BYTES(DB)) dut_i (
    .clk(clk), .rst_n(rst_n), .raw_vld(raw_vld), .raw_bit(raw_bit),
    .byte_out(byte_out), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .hdr_fmt(hdr_fmt), .hdr_trk(hdr_trk), .hdr_sec(hdr_sec), .hdr_gap(hdr_gap),
    .sect_done(sect_done), .hdr_good(hdr_good), .dat_good(dat_good), .sect_err(sect_err),
    .enc_vld(enc_vld), .enc_bit(enc_bit), .enc_pair(enc_pair), .enc_pair_vld(enc_pair_vld));

  int n_cmp = 0, n_bad = 0, rx = 0, nbytes = 0, cyc = 0, idle_cnt = 0;
  logic [7:0] exp_b [TOT];
  logic exp_hg, exp_dg;
  logic bprev = 0;

  task automatic chk(input bit ok, input string r, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(0, "watchdog", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n && byte_vld) begin
    chk(byte_out == exp_b[rx], "R3 byte", byte_out, exp_b[rx]);
    chk(byte_dat == (rx >= HB + 8), "R11 payload flag", byte_dat, rx >= HB + 8);
    chk(sect_done == (rx == TOT - 1), "R8 done", sect_done, rx == TOT - 1);
    if (sect_done) begin
      chk({hdr_fmt, hdr_trk, hdr_sec, hdr_gap} == {exp_b[0], exp_b[1], exp_b[2], exp_b[3]},
          "R5 header", {hdr_fmt, hdr_trk, hdr_sec, hdr_gap}, {exp_b[0], exp_b[1], exp_b[2], exp_b[3]});
      chk(hdr_good == exp_hg, "R6 hdr csum", hdr_good, exp_hg);
      chk(dat_good == exp_dg, "R7 data csum", dat_good, exp_dg);
    end
    rx = (rx == TOT - 1) ? 0 : rx + 1;
    nbytes++;
  end

  // R4: idle cycles with garbage bits are interleaved
  task automatic put_raw(input logic b);
    idle_cnt++;
    if (idle_cnt % 7 == 3) begin
      @(negedge clk); raw_vld = 0; raw_bit = ~b;
    end
    @(negedge clk); raw_vld = 1; raw_bit = b;
  endtask

  task automatic put_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) put_raw(w[i]);
    bprev = w[0];
  endtask

  task automatic put_byte(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      put_raw(~bprev & ~d[i]);
      put_raw(d[i]);
      bprev = d[i];
    end
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) put_byte(8'h00);
  endtask

  task automatic send_sector(input int trk, input int sec, input bit bad_h, input bit bad_d);
    logic [7:0] hx [4];
    logic [7:0] dx [4];
    exp_b[0] = 8'hFF; exp_b[1] = 8'(trk); exp_b[2] = 8'(sec); exp_b[3] = 8'(11 - sec);
    for (int i = 4; i < HB; i++) exp_b[i] = 8'(trk * 13 + sec * 5 + i);
    for (int i = HB + 8; i < TOT; i++) exp_b[i] = 8'(sec * 37 + i * 11 + trk);
    for (int j = 0; j < 4; j++) begin
      hx[j] = 0; dx[j] = 0;
      for (int k = 0; k < HB; k += 4) hx[j] ^= exp_b[k + j];
      for (int k = HB + 8; k < TOT; k += 4) dx[j] ^= exp_b[k + j];
      exp_b[HB + j]     = hx[j] ^ 8'((bad_h && j == 3) ? 1 : 0);
      exp_b[HB + 4 + j] = dx[j] ^ 8'((bad_d && j == 0) ? 8'h80 : 0);
    end
    exp_hg = !bad_h; exp_dg = !bad_d;
    gap(4);
    put_word(16'h4489);
    put_word(16'h4489);
    for (int i = 0; i < TOT; i++) put_byte(exp_b[i]);
    gap(3);
    chk(sect_err == (bad_h || bad_d), "R9 sticky err", sect_err, bad_h || bad_d);
  endtask

  initial begin
    int nb0;
    logic ep;
    repeat (3) @(negedge clk);
    chk(!byte_vld && !sect_done && !sect_err && !enc_pair_vld, "R1 reset",
        {byte_vld, sect_done, sect_err, enc_pair_vld}, 0);
    rst_n = 1;
    chk(!byte_vld && !sect_done && !sect_err && !enc_pair_vld, "R1 after reset",
        {byte_vld, sect_done, sect_err, enc_pair_vld}, 0);

    // R10 encoder sweep
    ep = 0;
    for (int v = 0; v < 256; v++)
      for (int i = 7; i >= 0; i--) begin
        @(negedge clk); enc_vld = 1; enc_bit = v[i];
        @(negedge clk); enc_vld = 0;
        chk(enc_pair_vld && enc_pair == {~ep & ~v[i], v[i]}, "R10 encode",
            {enc_pair_vld, enc_pair}, {1'b1, ~ep & ~v[i], v[i]});
        ep = v[i];
      end

    // R2 lone mark
    nb0 = nbytes;
    gap(3);
    put_word(16'h4489);
    gap(6);
    chk(nbytes == nb0, "R2 single mark", nbytes, nb0);

    // R8 track of 11 sectors, R6/R7/R9 corrupted sectors
    for (int s = 0; s < 11; s++)
      send_sector(s * 7 + 3, s, s == 3, s == 6 || s == 7);
    chk(nbytes == nb0 + 11 * TOT, "R8 byte count", nbytes, nb0 + 11 * TOT);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule